// File: doc/BRIEF.md
# Nested Zero-Overhead Loop Controller

This block sits beside an in-order fetch stage and removes the branch at the bottom of tight loops. It keeps a small set of loop descriptors, two by default. Each descriptor holds a first-instruction address, a last-instruction address and a remaining-iteration count. Every cycle it compares the presented fetch address against the last-instruction address of each live descriptor. When a live loop still has passes left, it asks fetch to go back to that loop's first instruction in the same cycle. It also takes one off that loop's count at the next clock edge.

Software programs the descriptors through a one-cycle write port. It can write the three fields one at a time. It can also issue a single compact command that carries the setup instruction's own address, the body length in instructions and the pass count. For the compact command, the body starts at the instruction right after the setup.

Descriptor 0 is the innermost loop and is served first. When the inner loop runs out on an address that is also the outer loop's last instruction, the outer loop takes the redirect in the same cycle. A setup that gives a zero count, or a body shorter than two instructions, raises an error pulse and leaves that descriptor idle. Any field can be read back combinationally.

Top module: `hwloop_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every descriptor's count reads 0, `jump_o` is low and `err_o` is low.
- R2: A write with `cfg_cmd` 0 stores `cfg_data` as the first-instruction address. With `cfg_cmd` 1 it stores the last-instruction address, and with `cfg_cmd` 2 it stores the count (low `CNT_W` bits). Each write goes to descriptor `cfg_loop`. The stored values appear on `rd_data` with `rd_sel` 0 for the first address, 1 for the last address and 2 for the count (zero-extended).
- R3: A write with `cfg_cmd` 3 sets the first address to `cfg_pc + 4` and the last address to `cfg_pc + 4*cfg_span`. It sets the count to the low `CNT_W` bits of `cfg_data`.
- R4: When `fetch_valid` is high, `fetch_pc` equals a served loop's last address and that loop's count exceeds 1, `jump_o` is high in the same cycle and `jump_target_o` equals that loop's first address. The count drops by one at the next edge.
- R5: When the served loop's count is exactly 1, `jump_o` stays low and the count becomes 0.
- R6: A descriptor whose count is 0 never causes a redirect and its count stays 0.
- R7: With `fetch_valid` low, or with `fetch_pc` matching no live last address, `jump_o` is low and no count changes.
- R8: When descriptors 0 and 1 both match and descriptor 0's count exceeds 1, only descriptor 0 redirects and decrements. Descriptor 1's count is unchanged.
- R9: When descriptor 0 matches with count 1 and descriptor 1 also matches with count above 1, descriptor 0 falls to 0 and descriptor 1 redirects and decrements in that same cycle.
- R10: A count write of 0, a compact write with count 0 or `cfg_span` below 2, or a count write while the last address is less than the first address plus 4, each pulse `err_o` high for the one cycle after the write. In each case the descriptor's count is left at 0.
- R11: A setup write to a descriptor in the same cycle as a matching fetch takes precedence over that descriptor's decrement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_valid | input | 1 | Fetch address is being consumed this cycle |
| fetch_pc | input | ADDR_W | Current fetch address |
| jump_o | output | 1 | Redirect fetch to `jump_target_o` |
| jump_target_o | output | ADDR_W | First address of the served loop |
| cfg_we | input | 1 | Setup write strobe |
| cfg_loop | input | LOOP_W | Descriptor selected by the write |
| cfg_cmd | input | 2 | 0 first addr, 1 last addr, 2 count, 3 compact setup |
| cfg_data | input | ADDR_W | Address or count value |
| cfg_pc | input | ADDR_W | Address of the compact setup instruction |
| cfg_span | input | SPAN_W | Body length in instructions for the compact setup |
| err_o | output | 1 | One-cycle pulse after a rejected setup |
| rd_loop | input | LOOP_W | Descriptor selected for readback |
| rd_sel | input | 2 | 0 first addr, 1 last addr, 2 count, 3 reads zero |
| rd_data | output | ADDR_W | Readback value |

## Verification
The assertions assume that `fetch_pc` and the setup port change only between clock edges. They also assume that software never points two live descriptors at overlapping bodies other than by proper nesting. The stimulus keeps every address word-aligned and keeps inner loops inside outer ones. Every setup write is a single-cycle strobe issued at a falling edge. The deliberate error cases and the write that coincides with a matching fetch are each issued alone, so that each expected count has exactly one cause.

// File: rtl/hwl_pkg.sv
// Shared encodings for the nested loop controller.
// Assumes a 2-bit command and a 2-bit readback selector on the top ports.
package hwl_pkg;
    typedef enum logic [1:0] {
        HWL_SET_FIRST = 2'd0,
        HWL_SET_LAST  = 2'd1,
        HWL_SET_COUNT = 2'd2,
        HWL_SET_SHORT = 2'd3
    } hwl_cmd_e;

    typedef enum logic [1:0] {
        HWL_RD_FIRST = 2'd0,
        HWL_RD_LAST  = 2'd1,
        HWL_RD_COUNT = 2'd2,
        HWL_RD_ZERO  = 2'd3
    } hwl_rsel_e;

    localparam int unsigned HWL_INSN_BYTES = 4;
    localparam int unsigned HWL_MIN_BODY   = 2;
endpackage

// File: rtl/hwl_loop_regs.sv
// One loop descriptor: first address, last address and pass count.
// Setup writes win over the decrement request. A rejected setup forces the
// count to zero and raises bad_o combinationally during the write cycle.
// Assumes instructions are HWL_INSN_BYTES wide and addresses word-aligned.
module hwl_loop_regs
    import hwl_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned SPAN_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  hwl_cmd_e          wr_cmd,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] wr_pc,
    input  logic [SPAN_W-1:0] wr_span,
    input  logic              dec,
    output logic [ADDR_W-1:0] first_o,
    output logic [ADDR_W-1:0] last_o,
    output logic [CNT_W-1:0]  cnt_o,
    output logic              bad_o
);
    localparam logic [ADDR_W:0] MIN_GAP = (ADDR_W+1)'(HWL_INSN_BYTES * (HWL_MIN_BODY - 1));

    logic [ADDR_W-1:0] first_q, last_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  wr_count;
    logic [ADDR_W-1:0] short_first, short_last;
    logic              long_body_ok;

    // Decode the compact form and the body-size rule for the long form.
    always_comb begin
        wr_count     = wr_data[CNT_W-1:0];
        short_first  = wr_pc + ADDR_W'(HWL_INSN_BYTES);
        short_last   = wr_pc + (ADDR_W'(wr_span) << 2);
        long_body_ok = {1'b0, last_q} >= ({1'b0, first_q} + MIN_GAP);
        bad_o = 1'b0;
        if (wr_en) begin
            if (wr_cmd == HWL_SET_COUNT)
                bad_o = (wr_count == '0) || !long_body_ok;
            else if (wr_cmd == HWL_SET_SHORT)
                bad_o = (wr_count == '0) || (wr_span < SPAN_W'(HWL_MIN_BODY));
        end
    end

    // Descriptor state: reset, setup writes, then decrement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_q <= '0;
            last_q  <= '0;
            cnt_q   <= '0;
        end else if (wr_en) begin
            unique case (wr_cmd)
                HWL_SET_FIRST: first_q <= wr_data;
                HWL_SET_LAST:  last_q  <= wr_data;
                HWL_SET_COUNT: cnt_q   <= bad_o ? '0 : wr_count;
                HWL_SET_SHORT: begin
                    first_q <= short_first;
                    last_q  <= short_last;
                    cnt_q   <= bad_o ? '0 : wr_count;
                end
            endcase
        end else if (dec) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign first_o = first_q;
    assign last_o  = last_q;
    assign cnt_o   = cnt_q;
endmodule

// File: rtl/hwl_arbiter.sv
// Chooses which descriptors act on the current fetch address.
// Lower index means inner loop and is served first. A matching loop on its
// final pass lets the next level see the same address. The first matching
// loop with passes left redirects and blocks all outer levels.
// Assumes live loops are properly nested.
module hwl_arbiter #(
    parameter int unsigned NUM_LOOPS = 2,
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned CNT_W     = 16
) (
    input  logic                 fetch_valid,
    input  logic [ADDR_W-1:0]    fetch_pc,
    input  logic [ADDR_W-1:0]    first_i [NUM_LOOPS],
    input  logic [ADDR_W-1:0]    last_i  [NUM_LOOPS],
    input  logic [CNT_W-1:0]     cnt_i   [NUM_LOOPS],
    output logic [NUM_LOOPS-1:0] take_o,
    output logic                 jump_o,
    output logic [ADDR_W-1:0]    target_o
);
    // Walk from the inner loop outward until a redirect is claimed.
    always_comb begin
        logic blocked;
        blocked  = 1'b0;
        take_o   = '0;
        jump_o   = 1'b0;
        target_o = '0;
        for (int i = 0; i < NUM_LOOPS; i++) begin
            if (fetch_valid && !blocked && (fetch_pc == last_i[i]) && (cnt_i[i] != '0)) begin
                take_o[i] = 1'b1;
                if (cnt_i[i] != CNT_W'(1)) begin
                    jump_o   = 1'b1;
                    target_o = first_i[i];
                    blocked  = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/hwloop_ctrl.sv
// Nested zero-overhead loop controller for an in-order fetch stage.
// Holds NUM_LOOPS descriptors, redirects fetch at a live loop's last
// instruction and accepts long-form or compact setup writes.
// Assumes fetch_pc is the address being consumed when fetch_valid is high.
module hwloop_ctrl
    import hwl_pkg::*;
#(
    parameter int unsigned NUM_LOOPS = 2,
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned CNT_W     = 16,
    parameter int unsigned SPAN_W    = 8,
    localparam int unsigned LOOP_W   = (NUM_LOOPS > 1) ? $clog2(NUM_LOOPS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_valid,
    input  logic [ADDR_W-1:0] fetch_pc,
    output logic              jump_o,
    output logic [ADDR_W-1:0] jump_target_o,
    input  logic              cfg_we,
    input  logic [LOOP_W-1:0] cfg_loop,
    input  logic [1:0]        cfg_cmd,
    input  logic [ADDR_W-1:0] cfg_data,
    input  logic [ADDR_W-1:0] cfg_pc,
    input  logic [SPAN_W-1:0] cfg_span,
    output logic              err_o,
    input  logic [LOOP_W-1:0] rd_loop,
    input  logic [1:0]        rd_sel,
    output logic [ADDR_W-1:0] rd_data
);
    logic [ADDR_W-1:0]    first_q [NUM_LOOPS];
    logic [ADDR_W-1:0]    last_q  [NUM_LOOPS];
    logic [CNT_W-1:0]     cnt_q   [NUM_LOOPS];
    logic [NUM_LOOPS-1:0] take;
    logic [NUM_LOOPS-1:0] bad;
    logic                 err_q;

    generate
        for (genvar g = 0; g < NUM_LOOPS; g++) begin : g_loop
            hwl_loop_regs #(
                .ADDR_W(ADDR_W), .CNT_W(CNT_W), .SPAN_W(SPAN_W)
            ) u_regs (
                .clk     (clk),
                .rst_n   (rst_n),
                .wr_en   (cfg_we && (cfg_loop == LOOP_W'(g))),
                .wr_cmd  (hwl_cmd_e'(cfg_cmd)),
                .wr_data (cfg_data),
                .wr_pc   (cfg_pc),
                .wr_span (cfg_span),
                .dec     (take[g]),
                .first_o (first_q[g]),
                .last_o  (last_q[g]),
                .cnt_o   (cnt_q[g]),
                .bad_o   (bad[g])
            );
        end
    endgenerate

    hwl_arbiter #(
        .NUM_LOOPS(NUM_LOOPS), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
    ) u_arb (
        .fetch_valid (fetch_valid),
        .fetch_pc    (fetch_pc),
        .first_i     (first_q),
        .last_i      (last_q),
        .cnt_i       (cnt_q),
        .take_o      (take),
        .jump_o      (jump_o),
        .target_o    (jump_target_o)
    );

    // Register a one-cycle error pulse for any rejected setup.
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= |bad;
    end
    assign err_o = err_q;

    // Combinational readback of the selected descriptor field.
    always_comb begin
        rd_data = '0;
        if (int'(rd_loop) < NUM_LOOPS) begin
            unique case (hwl_rsel_e'(rd_sel))
                HWL_RD_FIRST: rd_data = first_q[rd_loop];
                HWL_RD_LAST:  rd_data = last_q[rd_loop];
                HWL_RD_COUNT: rd_data = ADDR_W'(cnt_q[rd_loop]);
                HWL_RD_ZERO:  rd_data = '0;
            endcase
        end
    end
endmodule

// File: rtl/hwloop_ctrl_chk.sv
// Property checker for hwloop_ctrl, attached by bind below.
// Assumes the default two-level configuration.
module hwloop_ctrl_chk #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fetch_valid,
    input logic [ADDR_W-1:0] fetch_pc,
    input logic              jump_o,
    input logic [ADDR_W-1:0] jump_target_o,
    input logic              cfg_we,
    input logic              cfg_loop0,
    input logic [1:0]        cfg_cmd,
    input logic [ADDR_W-1:0] cfg_data,
    input logic              err_o,
    input logic [ADDR_W-1:0] first0,
    input logic [ADDR_W-1:0] last0,
    input logic [CNT_W-1:0]  cnt0,
    input logic [CNT_W-1:0]  cnt1
);
    logic hit0_multi;
    assign hit0_multi = fetch_valid && (fetch_pc == last0) && (cnt0 > CNT_W'(1));

    // R7
    idle_fetch_no_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_valid |-> !jump_o);

    // R6
    all_idle_no_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt0 == '0 && cnt1 == '0) |-> !jump_o);

    // R4
    inner_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit0_multi |-> (jump_o && jump_target_o == first0));

    // R4
    inner_decrement_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit0_multi && !(cfg_we && cfg_loop0)) |=> cnt0 == CNT_W'($past(cnt0) - CNT_W'(1)));

    // R8
    outer_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit0_multi && !(cfg_we && !cfg_loop0)) |=> cnt1 == $past(cnt1));

    // R10
    zero_count_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_cmd[1] && cfg_data[CNT_W-1:0] == '0) |=> err_o);
endmodule

bind hwloop_ctrl hwloop_ctrl_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .fetch_valid   (fetch_valid),
    .fetch_pc      (fetch_pc),
    .jump_o        (jump_o),
    .jump_target_o (jump_target_o),
    .cfg_we        (cfg_we),
    .cfg_loop0     (cfg_loop == '0),
    .cfg_cmd       (cfg_cmd),
    .cfg_data      (cfg_data),
    .err_o         (err_o),
    .first0        (first_q[0]),
    .last0         (last_q[0]),
    .cnt0          (cnt_q[0]),
    .cnt1          (cnt_q[1])
);

// File: tb/hwloop_ctrl_tb.sv
// Directed bench for hwloop_ctrl: one task per scenario.
module hwloop_ctrl_tb;
    localparam int AW = 32;
    localparam int SW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fetch_valid = 1'b0;
    logic [AW-1:0] fetch_pc = '0;
    logic          jump_o;
    logic [AW-1:0] jump_target_o;
    logic          cfg_we = 1'b0;
    logic [0:0]    cfg_loop = '0;
    logic [1:0]    cfg_cmd = '0;
    logic [AW-1:0] cfg_data = '0;
    logic [AW-1:0] cfg_pc = '0;
    logic [SW-1:0] cfg_span = '0;
    logic          err_o;
    logic [0:0]    rd_loop = '0;
    logic [1:0]    rd_sel = '0;
    logic [AW-1:0] rd_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic          last_err;
    logic          got_jump;
    logic [AW-1:0] got_tgt;

    hwloop_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
        .jump_o(jump_o), .jump_target_o(jump_target_o), .cfg_we(cfg_we),
        .cfg_loop(cfg_loop), .cfg_cmd(cfg_cmd), .cfg_data(cfg_data),
        .cfg_pc(cfg_pc), .cfg_span(cfg_span), .err_o(err_o),
        .rd_loop(rd_loop), .rd_sel(rd_sel), .rd_data(rd_data)
    );

    always #4 clk = ~clk;

    task automatic chk(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic rd(input int lp, input int sel, output logic [AW-1:0] v);
        rd_loop = 1'(lp);
        rd_sel  = 2'(sel);
        #1 v = rd_data;
    endtask

    task automatic chk_cnt(input string tag, input int lp, input int exp);
        logic [AW-1:0] v;
        rd(lp, 2, v);
        chk(tag, v, AW'(exp));
    endtask

    // One-cycle setup write; last_err holds err_o in the following cycle.
    task automatic cfg(input int lp, input int cmd, input logic [AW-1:0] data,
                       input logic [AW-1:0] pc, input int span);
        @(negedge clk);
        cfg_we = 1'b1; cfg_loop = 1'(lp); cfg_cmd = 2'(cmd);
        cfg_data = data; cfg_pc = pc; cfg_span = SW'(span);
        @(negedge clk);
        cfg_we = 1'b0;
        #1 last_err = err_o;
    endtask

    // Present one fetch address for one cycle and capture the redirect.
    task automatic step(input logic [AW-1:0] pc, input logic vld);
        @(negedge clk);
        fetch_pc = pc; fetch_valid = vld;
        #1 got_jump = jump_o; got_tgt = jump_target_o;
        @(negedge clk);
        fetch_valid = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        #1;
        chk("R1 jump after reset", AW'(jump_o), 0);
        chk("R1 err after reset", AW'(err_o), 0);
        chk_cnt("R1 count0 after reset", 0, 0);
        chk_cnt("R1 count1 after reset", 1, 0);
    endtask

    task automatic t_long();
        logic [AW-1:0] v;
        cfg(0, 0, 32'h100, 0, 0);
        cfg(0, 1, 32'h108, 0, 0);
        cfg(0, 2, 3, 0, 0);
        chk("R2 no error on good setup", AW'(last_err), 0);
        rd(0, 0, v); chk("R2 first readback", v, 32'h100);
        rd(0, 1, v); chk("R2 last readback", v, 32'h108);
        chk_cnt("R2 count readback", 0, 3);
        step(32'h104, 1'b1);
        chk("R7 mid-body no jump", AW'(got_jump), 0);
        chk_cnt("R7 mid-body count", 0, 3);
        step(32'h108, 1'b1);
        chk("R4 jump", AW'(got_jump), 1);
        chk("R4 target", got_tgt, 32'h100);
        chk_cnt("R4 decrement", 0, 2);
        step(32'h108, 1'b0);
        chk("R7 invalid fetch no jump", AW'(got_jump), 0);
        chk_cnt("R7 invalid fetch count", 0, 2);
        step(32'h108, 1'b1);
        chk("R4 second jump", AW'(got_jump), 1);
        chk_cnt("R4 second decrement", 0, 1);
        step(32'h108, 1'b1);
        chk("R5 last pass no jump", AW'(got_jump), 0);
        chk_cnt("R5 last pass count", 0, 0);
        step(32'h108, 1'b1);
        chk("R6 idle loop no jump", AW'(got_jump), 0);
        chk_cnt("R6 idle loop count", 0, 0);
    endtask

    task automatic t_short();
        logic [AW-1:0] v;
        cfg(1, 3, 2, 32'h200, 3);
        chk("R3 no error", AW'(last_err), 0);
        rd(1, 0, v); chk("R3 first = pc+4", v, 32'h204);
        rd(1, 1, v); chk("R3 last = pc+4*span", v, 32'h20C);
        chk_cnt("R3 count", 1, 2);
        step(32'h20C, 1'b1);
        chk("R3 jump to body start", got_tgt, 32'h204);
        chk_cnt("R3 decrement", 1, 1);
    endtask

    task automatic t_err();
        cfg(0, 2, 0, 0, 0);
        chk("R10 zero count error", AW'(last_err), 1);
        chk_cnt("R10 zero count idle", 0, 0);
        cfg(1, 3, 5, 32'h400, 1);
        chk("R10 short span error", AW'(last_err), 1);
        chk_cnt("R10 short span idle", 1, 0);
        cfg(0, 0, 32'h500, 0, 0);
        cfg(0, 1, 32'h500, 0, 0);
        cfg(0, 2, 4, 0, 0);
        chk("R10 long body too small error", AW'(last_err), 1);
        chk_cnt("R10 long body idle", 0, 0);
        cfg(0, 1, 32'h504, 0, 0);
        chk("R10 pulse lasts one cycle", AW'(last_err), 0);
    endtask

    task automatic t_nest();
        cfg(0, 0, 32'h304, 0, 0);
        cfg(0, 1, 32'h30C, 0, 0);
        cfg(0, 2, 2, 0, 0);
        cfg(1, 3, 3, 32'h2FC, 4);
        step(32'h30C, 1'b1);
        chk("R8 inner target", got_tgt, 32'h304);
        chk_cnt("R8 inner decrement", 0, 1);
        chk_cnt("R8 outer held", 1, 3);
        step(32'h30C, 1'b1);
        chk("R9 outer jump", AW'(got_jump), 1);
        chk("R9 outer target", got_tgt, 32'h300);
        chk_cnt("R9 inner exhausted", 0, 0);
        chk_cnt("R9 outer decrement", 1, 2);
    endtask

    task automatic t_override();
        cfg(0, 0, 32'h600, 0, 0);
        cfg(0, 1, 32'h608, 0, 0);
        cfg(0, 2, 5, 0, 0);
        @(negedge clk);
        fetch_pc = 32'h608; fetch_valid = 1'b1;
        cfg_we = 1'b1; cfg_loop = 1'b0; cfg_cmd = 2'd2; cfg_data = 9;
        #1 got_jump = jump_o;
        @(negedge clk);
        fetch_valid = 1'b0; cfg_we = 1'b0;
        chk("R11 jump still issued", AW'(got_jump), 1);
        chk_cnt("R11 write wins over decrement", 0, 9);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_long();
        t_short();
        t_err();
        t_nest();
        t_override();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule